// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block is the transmit half of an asynchronous serial port. The host places a byte, and optionally a ninth bit, into a one-entry holding register. The block moves that word into a transmit shift register and sends it on a single line in NRZ form. Each frame is a low start bit, the data bits with the least significant bit first, and one high stop bit. The line rests high between frames.

A baud divider inside the block sets the bit time. It counts down from an 8-bit or a 16-bit divisor and produces one tick every (divisor + 1) clocks. A bit lasts 16 ticks, or 64 ticks when both the high-speed select and the wide-divisor select are low.

The block reports two things. The holding-empty flag drives an interrupt, and its clearing after a write is seen one cycle late. A shift-idle status bit tells the host when nothing is on the line. Because of the holding register, the host can queue the next word while the current frame is still going out. That word then follows the stop bit with no idle gap.

Top module: `sertx_top`

## Requirements
- R1: After reset the line is high, shift-idle is 1, holding-empty is 0 and the interrupt output is 0.
- R2: While the transmitter is disabled, holding-empty reads 0. It reads 1 from the first clock edge after the enable is raised.
- R3: A frame is a start bit of 0, then 8 data bits with the LSB first, then a stop bit of 1. The line is 1 whenever no frame is in progress.
- R4: With nine-bit mode set, the ninth bit that was captured along with the byte is sent between data bit 7 and the stop bit.
- R5: One bit lasts M*(D+1) clocks. D is {hi,lo} when the wide-divisor select is 1, and lo alone otherwise, so the high byte is ignored. M is 64 when the high-speed and wide-divisor selects are both 0, and 16 in every other case.
- R6: A write accepted at edge E keeps holding-empty at 1 after E. It reads 0 after E+1. When the shifter was idle, the handoff makes it 1 again after E+2.
- R7: A word written during a frame waits in the holding register. It loads at the edge that ends the stop bit, so its start bit follows at once. Holding-empty stays 0 until that load, and it reads 1 one edge after the load.
- R8: Shift-idle is 0 from the load edge to the end of the stop bit, and 1 at all other times.
- R9: The interrupt output is 1 exactly when holding-empty is 1 and the interrupt enable is 1.
- R10: Clearing the enable stops any frame at the next edge. The line returns to 1, shift-idle returns to 1, and the held word is discarded.
- R11: A write presented while the transmitter is disabled is ignored. No frame follows when the transmitter is enabled afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_enable | input | 1 | Transmitter enable. Low aborts and empties both stages |
| irq_enable | input | 1 | Lets holding-empty drive irq |
| nine_bit_mode | input | 1 | Send a ninth data bit |
| ninth_bit | input | 1 | Ninth bit, captured with the write |
| wr_valid | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Data byte to queue |
| div_hi | input | 8 | Divisor high byte, used in wide mode only |
| div_lo | input | 8 | Divisor low byte |
| wide_div | input | 1 | Selects the 16-bit divisor |
| fast_mode | input | 1 | High-speed select for the oversampling factor |
| tx_line | output | 1 | Serial output, high when idle |
| buf_empty | output | 1 | Holding-empty flag |
| shift_empty | output | 1 | Shift-idle status, no interrupt attached |
| irq | output | 1 | Holding-empty interrupt |

## Verification
The bench targets the one-cycle-late clearing of holding-empty. A design that updated the flag at once would read 0 right after the write edge, and one that skipped the handoff would stay at 0. The bench writes the next word in the same cycle as a handoff, then checks that the word starts exactly at the stop-bit boundary. A design that loaded early would cut the stop bit short, and one that waited for an extra tick would leave a high gap. The start bit is timed to the exact clock in the 64x, wide-divisor and ignored-high-byte settings, which exposes a wrong multiplier choice or an off-by-one in the divisor. Aborting mid-frame and writing while disabled must leave the line high with no frame to follow.

// File: rtl/sertx_pkg.sv
// Shared constants and helpers for the serial transmitter.
// Assumes a frame of one start bit, DATA_W or DATA_W+1 data bits, one stop bit.
package sertx_pkg;
    localparam int OS_FAST_DEF = 16;
    localparam int OS_SLOW_DEF = 64;

    // Number of bit slots in a frame for the given data width and mode.
    function automatic int frame_len(input logic nine, input int data_w);
        return data_w + (nine ? 3 : 2);
    endfunction
endpackage

// File: rtl/sertx_baud.sv
// Baud tick generator: a down counter that reloads from the divisor on zero.
// A tick is one clock wide, and ticks come every (divisor+1) clocks.
// Assumes restart is pulsed when a frame loads, which aligns bit timing with the load edge.
module sertx_baud #(
    parameter int DIV_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               restart,
    input  logic               wide,
    input  logic [DIV_W/2-1:0] div_hi,
    input  logic [DIV_W/2-1:0] div_lo,
    output logic               tick
);
    localparam int HALF = DIV_W / 2;

    logic [DIV_W-1:0] divisor;
    logic [DIV_W-1:0] count;

    // Pick the 16-bit or the 8-bit divisor.
    always_comb divisor = wide ? {div_hi, div_lo} : {{HALF{1'b0}}, div_lo};

    // Count down. Reload on zero, on restart, or while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (!en || restart || count == '0)
            count <= divisor;
        else
            count <= count - 1'b1;
    end

    assign tick = en && (count == '0);

    // A tick is never followed by another unless the divisor is zero.
    assert_tick_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !restart && divisor != '0 && $stable(divisor)) |=> !tick);
endmodule

// File: rtl/sertx_shift.sv
// Transmit shift register with the frame sequencer.
// Builds start, data and stop slots on load, then shifts one slot per bit time.
// Assumes load is asserted only while idle or in the cycle that ends the stop bit.
module sertx_shift #(
    parameter int DATA_W  = 8,
    parameter int OS_FAST = sertx_pkg::OS_FAST_DEF,
    parameter int OS_SLOW = sertx_pkg::OS_SLOW_DEF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            tick,
    input  logic            slow,
    input  logic            load,
    input  logic            nine,
    input  logic [DATA_W:0] load_word,
    output logic            busy,
    output logic            line,
    output logic            frame_done
);
    localparam int FRAME_W = DATA_W + 3;
    localparam int SUB_W   = $clog2(OS_SLOW);
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    logic [FRAME_W-1:0] sreg;
    logic [CNT_W-1:0]   left;
    logic [SUB_W-1:0]   sub;
    logic [SUB_W-1:0]   sub_last;
    logic               bit_end;

    // Final tick count of one bit time for the selected oversampling factor.
    always_comb sub_last = slow ? SUB_W'(OS_SLOW - 1) : SUB_W'(OS_FAST - 1);

    assign bit_end    = busy && tick && (sub == sub_last);
    assign frame_done = bit_end && (left == CNT_W'(1));
    assign line       = sreg[0];

    // Load, shift, count ticks, and stop on abort.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            busy <= 1'b0;
            sreg <= '1;
            left <= '0;
            sub  <= '0;
        end else if (load) begin
            busy <= 1'b1;
            sreg <= {1'b1, (nine ? load_word[DATA_W] : 1'b1), load_word[DATA_W-1:0], 1'b0};
            left <= CNT_W'(sertx_pkg::frame_len(nine, DATA_W));
            sub  <= '0;
        end else if (bit_end) begin
            sreg <= {1'b1, sreg[FRAME_W-1:1]};
            left <= left - 1'b1;
            sub  <= '0;
            if (left == CNT_W'(1))
                busy <= 1'b0;
        end else if (busy && tick) begin
            sub <= sub + 1'b1;
        end
    end

    // A load always starts with the low start bit.
    assert_start_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && load) |=> (busy && !line));

    // Between ticks the line value is held.
    assert_bit_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && busy && !tick && !load) |=> $stable(sreg));

    // Disable aborts the frame at the next edge.
    assert_abort_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!busy && line));
endmodule

// File: rtl/sertx_top.sv
// Double-buffered asynchronous serial transmitter.
// Holds one queued word, hands it to the shifter when the shifter is idle or finishing,
// and keeps a holding-empty flag whose clearing is seen one cycle after the write.
// Assumes synchronous active-low reset and a write strobe one cycle wide.
module sertx_top #(
    parameter int DATA_W  = 8,
    parameter int DIV_W   = 16,
    parameter int OS_FAST = sertx_pkg::OS_FAST_DEF,
    parameter int OS_SLOW = sertx_pkg::OS_SLOW_DEF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tx_enable,
    input  logic               irq_enable,
    input  logic               nine_bit_mode,
    input  logic               ninth_bit,
    input  logic               wr_valid,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [DIV_W/2-1:0] div_hi,
    input  logic [DIV_W/2-1:0] div_lo,
    input  logic               wide_div,
    input  logic               fast_mode,
    output logic               tx_line,
    output logic               buf_empty,
    output logic               shift_empty,
    output logic               irq
);
    logic            hold_full;
    logic [DATA_W:0] hold_word;
    logic            wr_acc;
    logic            load;
    logic            tick;
    logic            busy;
    logic            frame_done;
    logic            slow;

    assign wr_acc = wr_valid && tx_enable;
    assign slow   = !fast_mode && !wide_div;
    assign load   = tx_enable && hold_full && (!busy || frame_done);

    // Holding register: a write fills it and a handoff empties it.
    always_ff @(posedge clk) begin
        if (!rst_n || !tx_enable) begin
            hold_full <= 1'b0;
            hold_word <= '0;
        end else begin
            if (load)
                hold_full <= 1'b0;
            if (wr_acc) begin
                hold_full <= 1'b1;
                hold_word <= {ninth_bit, wr_data};
            end
        end
    end

    // Holding-empty flag, one register behind the holding state.
    always_ff @(posedge clk) begin
        if (!rst_n)
            buf_empty <= 1'b0;
        else
            buf_empty <= tx_enable && !hold_full;
    end

    sertx_baud #(.DIV_W(DIV_W)) u_baud (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (tx_enable),
        .restart (load),
        .wide    (wide_div),
        .div_hi  (div_hi),
        .div_lo  (div_lo),
        .tick    (tick)
    );

    sertx_shift #(.DATA_W(DATA_W), .OS_FAST(OS_FAST), .OS_SLOW(OS_SLOW)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (tx_enable),
        .tick       (tick),
        .slow       (slow),
        .load       (load),
        .nine       (nine_bit_mode),
        .load_word  (hold_word),
        .busy       (busy),
        .line       (tx_line),
        .frame_done (frame_done)
    );

    assign shift_empty = !busy;
    assign irq         = buf_empty && irq_enable;

    // A write makes the flag read 0 two edges later.
    assert_flag_late_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_acc |-> ##2 !buf_empty);

    // Enabling sets the flag at the next edge.
    assert_enable_sets_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_enable) |=> buf_empty);

    // A waiting word with an idle shifter is handed off in one cycle.
    assert_handoff_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_enable && hold_full && shift_empty && !wr_acc) |=> (!hold_full && !shift_empty));

    // No frame can be in progress while disabled.
    assert_idle_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_enable |=> shift_empty);
endmodule

// File: tb/sertx_top_bench.sv
module sertx_top_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_enable = 1'b0;
    logic       irq_enable = 1'b0;
    logic       nine_bit_mode = 1'b0;
    logic       ninth_bit = 1'b0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] div_hi = 8'hFF;
    logic [7:0] div_lo = 8'd2;
    logic       wide_div = 1'b0;
    logic       fast_mode = 1'b1;
    logic       tx_line, buf_empty, shift_empty, irq;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    sertx_top u_sertx_top (
        .clk(clk), .rst_n(rst_n), .tx_enable(tx_enable), .irq_enable(irq_enable),
        .nine_bit_mode(nine_bit_mode), .ninth_bit(ninth_bit), .wr_valid(wr_valid),
        .wr_data(wr_data), .div_hi(div_hi), .div_lo(div_lo), .wide_div(wide_div),
        .fast_mode(fast_mode), .tx_line(tx_line), .buf_empty(buf_empty),
        .shift_empty(shift_empty), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic edges(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        @(negedge clk);
    endtask

    // Write strobe; returns at the negedge after the capturing edge.
    task automatic do_write(input logic [7:0] d, input logic nb);
        wr_valid  = 1'b1;
        wr_data   = d;
        ninth_bit = nb;
        edges(1);
        wr_valid  = 1'b0;
    endtask

    // Entered 'skew' edges after the load edge; checks every slot at its middle
    // and returns at the negedge after the edge that ends the stop bit.
    task automatic check_frame(input logic [8:0] w, input logic nine, input int p,
                               input int skew, input string req);
        int n;
        logic exp;
        n = nine ? 11 : 10;
        edges(p / 2 - skew);
        for (int j = 0; j < n; j++) begin
            if (j == 0) exp = 1'b0;
            else if (j <= 8) exp = w[j-1];
            else if (nine && j == 9) exp = w[8];
            else exp = 1'b1;
            chk(req, tx_line, exp);
            if (j < n - 1) edges(p);
        end
        edges(p - p / 2);
    endtask

    task automatic t_reset;
        chk("R1 line", tx_line, 1);
        chk("R1 shift_empty", shift_empty, 1);
        chk("R1 buf_empty", buf_empty, 0);
        chk("R1 irq", irq, 0);
    endtask

    task automatic t_enable;
        chk("R2 flag while disabled", buf_empty, 0);
        tx_enable = 1'b1;
        edges(1);
        chk("R2 flag after enable", buf_empty, 1);
    endtask

    task automatic t_irq;
        irq_enable = 1'b0;
        #1 chk("R9 irq masked", irq, 0);
        irq_enable = 1'b1;
        #1 chk("R9 irq enabled", irq, 1);
        irq_enable = 1'b0;
        edges(1);
    endtask

    // Idle write of one 8-bit frame with flag and status timing.
    task automatic t_frame8(input logic [7:0] d);
        do_write(d, 1'b0);
        chk("R6 flag after write edge", buf_empty, 1);
        edges(1);
        chk("R6 flag second edge", buf_empty, 0);
        chk("R8 busy at load", shift_empty, 0);
        chk("R3 start bit", tx_line, 0);
        edges(1);
        chk("R6 flag after handoff", buf_empty, 1);
        check_frame({1'b0, d}, 1'b0, 48, 1, "R3 frame bit");
        chk("R8 idle after stop", shift_empty, 1);
        chk("R3 line idle high", tx_line, 1);
    endtask

    task automatic t_nine(input logic [7:0] d, input logic nb);
        nine_bit_mode = 1'b1;
        do_write(d, nb);
        edges(1);
        check_frame({nb, d}, 1'b1, 48, 0, "R4 nine-bit frame");
        chk("R4 idle after stop", shift_empty, 1);
        nine_bit_mode = 1'b0;
    endtask

    // A second write lands in the same cycle as the handoff of the first.
    task automatic t_b2b(input logic [7:0] a, input logic [7:0] b);
        do_write(a, 1'b0);
        do_write(b, 1'b0);
        chk("R7 flag low while queued", buf_empty, 0);
        check_frame({1'b0, a}, 1'b0, 48, 0, "R7 first frame");
        chk("R7 second start follows stop", tx_line, 0);
        chk("R7 still busy", shift_empty, 0);
        chk("R7 flag before handoff seen", buf_empty, 0);
        edges(1);
        chk("R7 flag after handoff", buf_empty, 1);
        check_frame({1'b0, b}, 1'b0, 48, 1, "R7 second frame");
        chk("R8 idle after pair", shift_empty, 1);
    endtask

    // Exact start-bit length, then abort with the enable.
    task automatic t_start_len(input int p, input string req);
        do_write(8'h01, 1'b0);
        edges(1);
        chk(req, tx_line, 0);
        edges(p - 1);
        chk(req, tx_line, 0);
        edges(1);
        chk(req, tx_line, 1);
        tx_enable = 1'b0;
        edges(1);
        chk("R10 abort line", tx_line, 1);
        chk("R10 abort idle", shift_empty, 1);
        tx_enable = 1'b1;
        edges(1);
    endtask

    task automatic t_abort_mid;
        do_write(8'h00, 1'b0);
        do_write(8'h00, 1'b0);
        edges(100);
        tx_enable = 1'b0;
        edges(1);
        chk("R10 line after abort", tx_line, 1);
        chk("R10 idle after abort", shift_empty, 1);
        tx_enable = 1'b1;
        edges(1);
        chk("R10 held word dropped", buf_empty, 1);
        edges(600);
        chk("R10 no frame after re-enable", tx_line, 1);
        chk("R10 still idle", shift_empty, 1);
    endtask

    task automatic t_write_off;
        tx_enable = 1'b0;
        edges(1);
        do_write(8'h00, 1'b0);
        tx_enable = 1'b1;
        edges(1);
        chk("R11 flag empty", buf_empty, 1);
        edges(60);
        chk("R11 line stays high", tx_line, 1);
        chk("R11 no frame", shift_empty, 1);
    endtask

    initial begin : watchdog
        for (int i = 0; i < 150000; i++) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        edges(4);
        rst_n = 1'b1;
        edges(1);
        t_reset();
        t_enable();
        t_irq();
        t_frame8(8'hA6);
        t_frame8(8'h5B);
        t_nine(8'hA5, 1'b1);
        t_nine(8'h3C, 1'b0);
        t_b2b(8'hC3, 8'h1E);
        t_start_len(48, "R5 16x lo-only, hi ignored");
        fast_mode = 1'b0; wide_div = 1'b0; div_lo = 8'd1;
        t_start_len(128, "R5 64x rate");
        wide_div = 1'b1; div_hi = 8'h01; div_lo = 8'h00;
        t_start_len(4112, "R5 wide divisor 16x");
        fast_mode = 1'b1; wide_div = 1'b0; div_hi = 8'hFF; div_lo = 8'd2;
        t_abort_mid();
        t_write_off();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule